// File: doc/BRIEF.md
# Interlaced Field Weave Address Generator

This block turns a stream of line and field markers into burst write requests that place incoming video lines at the right places in a frame buffer. It writes a luma plane and an interleaved chroma plane. In progressive mode the lines of each frame go into consecutive rows of the buffer. In interlaced mode two fields are merged into one progressive buffer. Each field fills every other row, so the two fields sit one row apart and share one buffer.

Configuration comes in as plain inputs: base address, line width in bytes, frame height, chroma plane offset, chroma format and the interlace enable. The block copies these into a shadow set once after reset and then again only when it moves to a new buffer. Software can therefore set up the next frame while the current one is still being written. Each request is one burst on a simple valid/ready handshake. A one-cycle done pulse marks every buffer that has been filled.

Top module: `weave_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `req_valid` and `frame_done` are 0.
- R2: In progressive mode, luma line k of a frame starts at base + k*W (W = width in bytes). Each line is split into bursts of 64 beats, and consecutive bursts of a line are 64*BEAT_BYTES bytes apart.
- R3: In interlaced mode every burst is 16 beats and the row step inside a field is 2*W. The even field (`field` = 1) starts at base and the odd field (`field` = 0) starts at base + W.
- R4: A field holds H/2 lines in interlaced mode and H lines in progressive mode. Any `line_start` beyond that count, before the next `field_end`, produces no request.
- R5: After the luma bursts of a line, chroma bursts (`req_chroma` = 1) follow with no gap. For 4:2:2 (`fmt422` = 1) this happens on every line; for 4:2:0 it happens only on lines with an even index within the field. Chroma line j starts at base + chroma offset + field offset + j*cstride. Here P = W for 4:2:0 and 2*W for 4:2:2. The field offset is P for the odd field in interlaced mode and 0 otherwise. The cstride is 2*P interlaced and P progressive.
- R6: The luma and chroma row counters restart at zero at every `field_end`, so the next field's first line starts at that field's own start address.
- R7: In interlaced mode a `field_end` with `field` = 1 keeps the current buffer and gives no done pulse. A `field_end` with `field` = 0 moves to a new buffer. In progressive mode every `field_end` moves to a new buffer. A buffer move gives exactly a one-cycle `frame_done` pulse, in the cycle after the `field_end` cycle.
- R8: Configuration inputs are taken only at a buffer move (and once after reset). Changes at any other time do not affect addresses.
- R9: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_addr`, `req_len` and `req_chroma` are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_base | input | AW | Frame buffer base address |
| cfg_width | input | WW | Bytes per luma line |
| cfg_height | input | HW | Frame height in lines |
| cfg_c_offs | input | AW | Chroma plane offset from base |
| cfg_fmt422 | input | 1 | 1 = 4:2:2 chroma, 0 = 4:2:0 |
| cfg_ilace | input | 1 | 1 = interlaced weave |
| line_start | input | 1 | Pulse: a line of the current field begins |
| field | input | 1 | Field polarity, 0 odd, 1 even |
| field_end | input | 1 | Pulse: current field (polarity on `field`) ended |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted |
| req_addr | output | AW | Burst start byte address |
| req_len | output | LW | Burst length in beats |
| req_chroma | output | 1 | 1 = chroma plane burst |
| frame_done | output | 1 | One-cycle pulse on buffer move |

## Verification
The assertions check four things on every cycle: a stalled request is held steady, the burst length is always one of the two legal values, the done pulse lasts one cycle and follows a field end, and chroma bursts follow the last luma burst of a line directly. The actual address arithmetic can only be shown by the bench's scenarios. That covers the field start offsets, the doubled strides, the chroma pitch per format, the line-count cut-off, the counter restart per field, and config being taken only at a buffer move. Each scenario compares captured requests against addresses computed from the requirements.

// File: rtl/wv_pkg.sv
package wv_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LUMA   = 2'd1,
        PH_CHROMA = 2'd2
    } phase_e;
endpackage

// File: rtl/wv_cfg_shadow.sv
module wv_cfg_shadow #(
    parameter int AW = 32,
    parameter int WW = 16,
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] in_base,
    input  logic [WW-1:0] in_width,
    input  logic [HW-1:0] in_height,
    input  logic [AW-1:0] in_c_offs,
    input  logic          in_fmt422,
    input  logic          in_ilace,
    output logic [AW-1:0] sh_base,
    output logic [WW-1:0] sh_width,
    output logic [HW-1:0] sh_height,
    output logic [AW-1:0] sh_c_offs,
    output logic          sh_fmt422,
    output logic          sh_ilace
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [WW-1:0] width;
        logic [HW-1:0] height;
        logic [AW-1:0] c_offs;
        logic          fmt422;
        logic          ilace;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.base   = in_base;
            sh_d.width  = in_width;
            sh_d.height = in_height;
            sh_d.c_offs = in_c_offs;
            sh_d.fmt422 = in_fmt422;
            sh_d.ilace  = in_ilace;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sh_base   = sh_q.base;
    assign sh_width  = sh_q.width;
    assign sh_height = sh_q.height;
    assign sh_c_offs = sh_q.c_offs;
    assign sh_fmt422 = sh_q.fmt422;
    assign sh_ilace  = sh_q.ilace;
endmodule

// File: rtl/wv_geom.sv
module wv_geom #(
    parameter int AW         = 32,
    parameter int WW         = 16,
    parameter int HW         = 12,
    parameter int LW         = 7,
    parameter int BEAT_BYTES = 4,
    parameter int LEN_IL     = 16,
    parameter int LEN_PR     = 64
) (
    input  logic [WW-1:0] width,
    input  logic [HW-1:0] height,
    input  logic          fmt422,
    input  logic          ilace,
    input  logic          fld,
    output logic [HW-1:0] lines_per_field,
    output logic [AW-1:0] y_stride,
    output logic [AW-1:0] y_foff,
    output logic [AW-1:0] c_stride,
    output logic [AW-1:0] c_foff,
    output logic [LW-1:0] burst_len,
    output logic [AW-1:0] burst_bytes
);
    localparam logic [AW-1:0] BB_IL = AW'(LEN_IL * BEAT_BYTES);
    localparam logic [AW-1:0] BB_PR = AW'(LEN_PR * BEAT_BYTES);

    logic [AW-1:0] w_ext;
    logic [AW-1:0] c_pitch;
    logic          lower_field;

    always_comb begin
        w_ext           = AW'(width);
        c_pitch         = fmt422 ? (w_ext << 1) : w_ext;
        lower_field     = ilace && !fld;
        lines_per_field = ilace ? (height >> 1) : height;
        y_stride        = ilace ? (w_ext << 1) : w_ext;
        y_foff          = lower_field ? w_ext : '0;
        c_stride        = ilace ? (c_pitch << 1) : c_pitch;
        c_foff          = lower_field ? c_pitch : '0;
        burst_len       = ilace ? LW'(LEN_IL) : LW'(LEN_PR);
        burst_bytes     = ilace ? BB_IL : BB_PR;
    end
endmodule

// File: rtl/weave_addr_gen.sv
module weave_addr_gen #(
    parameter int AW         = 32,
    parameter int WW         = 16,
    parameter int HW         = 12,
    parameter int LW         = 7,
    parameter int BEAT_BYTES = 4,
    parameter int LEN_IL     = 16,
    parameter int LEN_PR     = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [WW-1:0] cfg_width,
    input  logic [HW-1:0] cfg_height,
    input  logic [AW-1:0] cfg_c_offs,
    input  logic          cfg_fmt422,
    input  logic          cfg_ilace,
    input  logic          line_start,
    input  logic          field,
    input  logic          field_end,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [AW-1:0] req_addr,
    output logic [LW-1:0] req_len,
    output logic          req_chroma,
    output logic          frame_done
);
    import wv_pkg::*;

    typedef struct packed {
        phase_e        phase;
        logic          fld;
        logic [HW-1:0] line_cnt;
        logic [AW-1:0] y_off;
        logic [AW-1:0] c_off;
        logic [AW-1:0] byte_pos;
        logic          primed;
        logic          done;
    } state_t;

    state_t st_d, st_q;
    logic   load;

    logic [AW-1:0] sh_base, sh_c_offs;
    logic [WW-1:0] sh_width;
    logic [HW-1:0] sh_height;
    logic          sh_fmt422, sh_ilace;

    logic [HW-1:0] lines_per_field;
    logic [AW-1:0] y_stride, y_foff, c_stride, c_foff, burst_bytes;
    logic [LW-1:0] burst_len;
    logic          last_burst, chroma_line;

    wv_cfg_shadow #(.AW(AW), .WW(WW), .HW(HW)) u_shadow (
        .clk(clk), .rst_n(rst_n), .load(load),
        .in_base(cfg_base), .in_width(cfg_width), .in_height(cfg_height),
        .in_c_offs(cfg_c_offs), .in_fmt422(cfg_fmt422), .in_ilace(cfg_ilace),
        .sh_base(sh_base), .sh_width(sh_width), .sh_height(sh_height),
        .sh_c_offs(sh_c_offs), .sh_fmt422(sh_fmt422), .sh_ilace(sh_ilace)
    );

    wv_geom #(
        .AW(AW), .WW(WW), .HW(HW), .LW(LW), .BEAT_BYTES(BEAT_BYTES),
        .LEN_IL(LEN_IL), .LEN_PR(LEN_PR)
    ) u_geom (
        .width(sh_width), .height(sh_height), .fmt422(sh_fmt422),
        .ilace(sh_ilace), .fld(st_q.fld),
        .lines_per_field(lines_per_field), .y_stride(y_stride), .y_foff(y_foff),
        .c_stride(c_stride), .c_foff(c_foff), .burst_len(burst_len),
        .burst_bytes(burst_bytes)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        load        = 1'b0;
        last_burst  = (st_q.byte_pos + burst_bytes) >= AW'(sh_width);
        chroma_line = sh_fmt422 || !st_q.line_cnt[0];

        if (!st_q.primed) begin
            load        = 1'b1;
            st_d.primed = 1'b1;
        end

        unique case (st_q.phase)
            PH_IDLE: begin
                if (st_q.primed && field_end) begin
                    st_d.line_cnt = '0;
                    st_d.y_off    = '0;
                    st_d.c_off    = '0;
                    if (!sh_ilace || !field) begin
                        load      = 1'b1;
                        st_d.done = 1'b1;
                    end
                end else if (st_q.primed && line_start &&
                             (st_q.line_cnt < lines_per_field)) begin
                    st_d.fld      = field;
                    st_d.byte_pos = '0;
                    st_d.phase    = PH_LUMA;
                end
            end
            PH_LUMA: begin
                if (req_ready) begin
                    if (last_burst) begin
                        st_d.byte_pos = '0;
                        st_d.y_off    = st_q.y_off + y_stride;
                        if (chroma_line) begin
                            st_d.phase = PH_CHROMA;
                        end else begin
                            st_d.phase    = PH_IDLE;
                            st_d.line_cnt = st_q.line_cnt + HW'(1);
                        end
                    end else begin
                        st_d.byte_pos = st_q.byte_pos + burst_bytes;
                    end
                end
            end
            PH_CHROMA: begin
                if (req_ready) begin
                    if (last_burst) begin
                        st_d.byte_pos = '0;
                        st_d.c_off    = st_q.c_off + c_stride;
                        st_d.phase    = PH_IDLE;
                        st_d.line_cnt = st_q.line_cnt + HW'(1);
                    end else begin
                        st_d.byte_pos = st_q.byte_pos + burst_bytes;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        req_valid  = (st_q.phase == PH_LUMA) || (st_q.phase == PH_CHROMA);
        req_chroma = (st_q.phase == PH_CHROMA);
        req_len    = burst_len;
        if (st_q.phase == PH_CHROMA)
            req_addr = sh_base + sh_c_offs + c_foff + st_q.c_off + st_q.byte_pos;
        else
            req_addr = sh_base + y_foff + st_q.y_off + st_q.byte_pos;
    end

    assign frame_done = st_q.done;
endmodule

// File: rtl/wv_checker.sv
module wv_checker #(
    parameter int AW     = 32,
    parameter int LW     = 7,
    parameter int LEN_IL = 16,
    parameter int LEN_PR = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [LW-1:0] req_len,
    input logic          req_chroma,
    input logic          frame_done,
    input logic          field_end
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                       $stable(req_len) && $stable(req_chroma)));

    assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len == LW'(LEN_IL) || req_len == LW'(LEN_PR)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(field_end));

    assert_chroma_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid && req_chroma) |-> $past(req_valid && !req_chroma && req_ready));
endmodule

bind weave_addr_gen wv_checker #(
    .AW(AW), .LW(LW), .LEN_IL(LEN_IL), .LEN_PR(LEN_PR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_chroma(req_chroma),
    .frame_done(frame_done), .field_end(field_end)
);

// File: tb/weave_addr_gen_tb.sv
module weave_addr_gen_tb;
    localparam int AW = 32, WW = 16, HW = 12, LW = 7;
    localparam int W  = 256;
    localparam logic [AW-1:0] COFF = 32'h8000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_base = 32'h1000;
    logic [WW-1:0] cfg_width = WW'(W);
    logic [HW-1:0] cfg_height = HW'(4);
    logic [AW-1:0] cfg_c_offs = COFF;
    logic          cfg_fmt422 = 1'b1;
    logic          cfg_ilace = 1'b0;
    logic          line_start = 1'b0, field = 1'b1, field_end = 1'b0;
    logic          req_ready = 1'b1;
    logic          req_valid, req_chroma, frame_done;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] req_len;

    int checks = 0, fails = 0;
    logic [AW-1:0] cap_addr [0:63];
    int            cap_len  [0:63];
    logic          cap_ch   [0:63];
    int            ncap = 0;

    always #5 clk = ~clk;

    weave_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_width(cfg_width),
        .cfg_height(cfg_height), .cfg_c_offs(cfg_c_offs), .cfg_fmt422(cfg_fmt422),
        .cfg_ilace(cfg_ilace), .line_start(line_start), .field(field),
        .field_end(field_end), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_chroma(req_chroma),
        .frame_done(frame_done)
    );

    always @(negedge clk) begin
        if (rst_n && req_valid && req_ready && ncap < 64) begin
            cap_addr[ncap] = req_addr;
            cap_len[ncap]  = int'(req_len);
            cap_ch[ncap]   = req_chroma;
            ncap++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_req(input int i, input logic [AW-1:0] a, input int len,
                           input logic ch, input string req);
        chk(cap_addr[i] == a, req, cap_addr[i], a);
        chk(cap_len[i] == len, req, cap_len[i], len);
        chk(cap_ch[i] == ch, req, cap_ch[i], ch);
    endtask

    task automatic do_line(input logic f);
        @(posedge clk); #1 line_start = 1'b1; field = f;
        @(posedge clk); #1 line_start = 1'b0;
        repeat (20) @(posedge clk);
        #1;
    endtask

    task automatic do_field_end(input logic f, input logic exp_done, input string req);
        @(posedge clk); #1 field_end = 1'b1; field = f;
        @(posedge clk); #1 field_end = 1'b0;
        chk(frame_done == exp_done, req, frame_done, exp_done);
        @(posedge clk); #1;
        chk(frame_done == 1'b0, req, frame_done, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #1;
        chk(req_valid == 1'b0 && frame_done == 1'b0, "R1 during reset", {req_valid, frame_done}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(req_valid == 1'b0 && frame_done == 1'b0, "R1 after reset", {req_valid, frame_done}, 0);
    endtask

    task automatic t_progressive_422;
        ncap = 0;
        for (int k = 0; k < 4; k++) do_line(1'b1);
        chk(ncap == 8, "R2 request count", ncap, 8);
        for (int k = 0; k < 4; k++) begin
            chk_req(2*k,   32'h1000 + AW'(k*W), 64, 1'b0, "R2 progressive luma");
            chk_req(2*k+1, 32'h1000 + COFF + AW'(k*2*W), 64, 1'b1, "R5 progressive 422 chroma");
        end
        do_line(1'b1);
        chk(ncap == 8, "R4 extra line ignored progressive", ncap, 8);
        // next buffer: interlaced 4:2:0 at new base
        cfg_base = 32'h2000; cfg_ilace = 1'b1; cfg_fmt422 = 1'b0;
        do_field_end(1'b1, 1'b1, "R7 progressive advance");
    endtask

    task automatic t_interlaced_420;
        logic [AW-1:0] b;
        b = 32'h2000;
        ncap = 0;
        do_line(1'b1);
        do_line(1'b1);
        chk(ncap == 12, "R4 even field count", ncap, 12);
        for (int k = 0; k < 4; k++) begin
            chk_req(k,   b + AW'(k*64), 16, 1'b0, "R3 even luma line0");
            chk_req(4+k, b + COFF + AW'(k*64), 16, 1'b1, "R5 even chroma line0");
            chk_req(8+k, b + AW'(2*W + k*64), 16, 1'b0, "R3 even luma stride");
        end
        do_line(1'b1);
        chk(ncap == 12, "R4 third line ignored", ncap, 12);
        cfg_base = 32'h3000;
        do_field_end(1'b1, 1'b0, "R7 even field holds buffer");
        ncap = 0;
        do_line(1'b0);
        do_line(1'b0);
        chk(ncap == 12, "R4 odd field count", ncap, 12);
        for (int k = 0; k < 4; k++) begin
            chk_req(k,   b + AW'(W + k*64), 16, 1'b0, "R6 odd luma restart");
            chk_req(4+k, b + COFF + AW'(W + k*64), 16, 1'b1, "R5 odd chroma offset W");
            chk_req(8+k, b + AW'(3*W + k*64), 16, 1'b0, "R3 odd luma line1");
        end
        chk(cap_addr[0] < 32'h3000, "R8 base held mid buffer", cap_addr[0], b + AW'(W));
        do_field_end(1'b0, 1'b1, "R7 odd field advances");
    endtask

    task automatic t_stall;
        ncap = 0;
        req_ready = 1'b0;
        @(posedge clk); #1 line_start = 1'b1; field = 1'b1;
        @(posedge clk); #1 line_start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(req_valid == 1'b1 && req_addr == 32'h3000 && req_chroma == 1'b0,
                "R9 held while stalled", req_addr, 32'h3000);
            @(posedge clk); #1;
        end
        chk(req_len == 7'd16, "R9 length held", req_len, 16);
        req_ready = 1'b1;
        repeat (20) @(posedge clk);
        #1;
        chk(ncap == 8, "R9 stall count", ncap, 8);
        chk_req(0, 32'h3000, 16, 1'b0, "R8 new base after advance");
        cfg_fmt422 = 1'b1;
        do_field_end(1'b1, 1'b0, "R7 even end holds");
        do_field_end(1'b0, 1'b1, "R7 odd end advances");
    endtask

    task automatic t_interlaced_422;
        ncap = 0;
        do_line(1'b0);
        do_line(1'b0);
        chk(ncap == 16, "R5 422 chroma every line", ncap, 16);
        for (int k = 0; k < 4; k++) begin
            chk_req(k,    32'h3000 + AW'(W + k*64), 16, 1'b0, "R3 odd luma start");
            chk_req(4+k,  32'h3000 + COFF + AW'(2*W + k*64), 16, 1'b1, "R5 422 odd chroma 2W");
            chk_req(12+k, 32'h3000 + COFF + AW'(2*W + 4*W + k*64), 16, 1'b1, "R5 422 chroma stride");
        end
    endtask

    initial begin
        t_reset();
        t_progressive_422();
        t_interlaced_420();
        t_stall();
        t_interlaced_422();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule